// File: doc/BRIEF.md
# Shared-Address Scratchpad and Auxiliary Status Register

This block sits in the register file of a serial and infrared communication controller. One CPU address maps to two different bytes. When the controller is not in extended mode, the address holds a general-purpose scratchpad byte that software can use freely and that affects nothing in the device. When extended mode is active, the same address holds an auxiliary status and control byte. That byte gathers conditions from the receive FIFO, the transmit FIFO, the frame logic and the timeout logic. It also gives software two controls: it can mark the end of a transmission, and it can restart a transmitter that has halted.

Each auxiliary bit has its own rules for set, clear and reset. Some bits follow a level. Some are sticky until an event clears them. One is set by software and cleared by hardware. One is set by hardware and cleared when software writes 1 to it. A hardware reset or an operational-mode change clears the whole auxiliary byte. A transmitter soft reset and a receiver soft reset each clear only their own group of bits. The scratchpad is cleared only by a hardware reset.

Top module: `aux_status_reg`

## Requirements
- R1: `cpuRdData` shows the auxiliary byte while `extMode` is 1 and the scratchpad byte while `extMode` is 0. The read is combinational.
- R2: The active-low `rstN` clears the auxiliary byte and the scratchpad. A `modeChange` pulse clears all eight auxiliary bits at the next clock edge.
- R3: A `txSoftRst` pulse clears only auxiliary bits 2 and 6. A `rxSoftRst` pulse clears only auxiliary bits 0, 1, 4 and 5.
- R4: Bit 0 (receive timeout) sets on `rxTimeout` and clears on `rxFifoRead`. When both arrive in the same cycle, the clear wins.
- R5: Bit 1 equals `frameEndInFifo` as sampled at the previous clock edge. It is 0 after a receiver soft reset or a mode change.
- R6: Bit 2 (end-of-transmission mark) is set when the CPU writes a 1 to bit 2 in extended mode. It clears at the edge that accepts a `txFifoWrite`, and that clear wins over a set in the same cycle. `txEotMark` is high in any cycle where `txFifoWrite` is high and bit 2 is 1.
- R7: Bit 3 (transmitter halted) sets when `frameLenDone` and `frameStopMode` are both high. Only an extended-mode CPU write with bit 3 equal to 1 clears it, and a set in the same cycle wins. `txHalted` equals bit 3.
- R8: Bit 4 equals `lostFrame` as sampled at the previous clock edge. It is 0 after a receiver soft reset or a mode change.
- R9: Bits 5, 6 and 7 are sticky copies of `auxEvent[0]`, `auxEvent[1]` and `auxEvent[2]`. Bit 7 is cleared only by a hardware reset or a mode change.
- R10: An extended-mode CPU write has no effect on bits 0, 1 and 4 to 7, and a 0 written to bit 2 or bit 3 has no effect. Such a write leaves the scratchpad unchanged, and a non-extended write leaves the auxiliary byte unchanged.
- R11: A non-extended CPU write loads the scratchpad. The scratchpad keeps its value across mode changes, soft resets and extended-mode writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| extMode | input | 1 | 1 selects the auxiliary byte at the shared address |
| modeChange | input | 1 | Pulse when the operational mode changes |
| txSoftRst | input | 1 | Transmitter soft-reset pulse |
| rxSoftRst | input | 1 | Receiver soft-reset pulse |
| cpuSel | input | 1 | CPU address matches the shared address |
| cpuWr | input | 1 | CPU write strobe |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data for the shared address |
| rxTimeout | input | 1 | Receive FIFO timeout event |
| rxFifoRead | input | 1 | A character was read from the receive FIFO |
| frameEndInFifo | input | 1 | At least one frame-end byte is in the receive FIFO |
| txFifoWrite | input | 1 | A character is being written into the transmit FIFO |
| frameLenDone | input | 1 | The frame-length counter reached zero at frame end |
| frameStopMode | input | 1 | Frame-end stop mode is selected |
| lostFrame | input | 1 | Lost-frame flag at the bottom of the status FIFO |
| auxEvent | input | 3 | Status events latched into bits 5 to 7 |
| txEotMark | output | 1 | Marks the current transmit FIFO write as the last character |
| txHalted | output | 1 | Transmitter halted on frame end |

## Verification
Every auxiliary and scratchpad update comes from one register stage. A stimulus applied before a clock edge shows up on `cpuRdData` just after that edge. `cpuRdData` and `txEotMark` themselves are combinational in the current cycle. The bench changes inputs 1 ns after a rising edge and updates its model at the following rising edge. It compares the outputs 1 ns later, and it reads both bytes in that window by flipping `extMode` and waiting 1 ns for the read path to settle. Each auxiliary bit is checked on its own against the model, under its own requirement tag, across a long pseudo-random sweep that also covers collisions between pulses.

// File: rtl/aux_status_pkg.sv
package aux_status_pkg;
  parameter int DATA_W = 8;
  localparam int EV_W    = 3;
  localparam int B_TOUT  = 0;
  localparam int B_FEND  = 1;
  localparam int B_EOT   = 2;
  localparam int B_HALT  = 3;
  localparam int B_LOST  = 4;
  localparam int B_EV0   = 5;
  localparam logic [DATA_W-1:0] RX_CLR_MASK = DATA_W'(8'b0011_0011);
  localparam logic [DATA_W-1:0] TX_CLR_MASK = DATA_W'(8'b0100_0100);

  typedef struct packed {
    logic scrWr;
    logic eotSet;
    logic haltClr;
    logic clrAll;
    logic clrRx;
    logic clrTx;
  } auxStrobeT;
endpackage

// File: rtl/aux_status_ctrl.sv
module aux_status_ctrl
  import aux_status_pkg::*;
(
  input  logic              extMode,
  input  logic              modeChange,
  input  logic              txSoftRst,
  input  logic              rxSoftRst,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output auxStrobeT         strobe
);
  logic wrHit;
  logic auxWr;

  always_comb begin
    wrHit  = cpuSel & cpuWr;
    auxWr  = wrHit & extMode;
    strobe = '0;
    strobe.scrWr   = wrHit & ~extMode;
    strobe.eotSet  = auxWr & cpuWrData[B_EOT];
    strobe.haltClr = auxWr & cpuWrData[B_HALT];
    strobe.clrAll  = modeChange;
    strobe.clrRx   = rxSoftRst;
    strobe.clrTx   = txSoftRst;
  end
endmodule

// File: rtl/aux_status_dp.sv
module aux_status_dp
  import aux_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  auxStrobeT         strobe,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              rxTimeout,
  input  logic              rxFifoRead,
  input  logic              frameEndInFifo,
  input  logic              txFifoWrite,
  input  logic              frameLenDone,
  input  logic              frameStopMode,
  input  logic              lostFrame,
  input  logic [EV_W-1:0]   auxEvent,
  output logic [DATA_W-1:0] auxQ,
  output logic [DATA_W-1:0] scrQ
);
  logic rxGrpClr;
  logic txGrpClr;
  assign rxGrpClr = strobe.clrAll | strobe.clrRx;
  assign txGrpClr = strobe.clrAll | strobe.clrTx;

  // scratchpad: only hardware reset or a non-extended write touches it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             scrQ <= '0;
    else if (strobe.scrWr) scrQ <= cpuWrData;
  end

  // receive timeout: read clear beats timeout set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           auxQ[B_TOUT] <= 1'b0;
    else if (rxGrpClr)   auxQ[B_TOUT] <= 1'b0;
    else if (rxFifoRead) auxQ[B_TOUT] <= 1'b0;
    else if (rxTimeout)  auxQ[B_TOUT] <= 1'b1;
  end

  // level mirrors
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      auxQ[B_FEND] <= 1'b0;
      auxQ[B_LOST] <= 1'b0;
    end else if (rxGrpClr) begin
      auxQ[B_FEND] <= 1'b0;
      auxQ[B_LOST] <= 1'b0;
    end else begin
      auxQ[B_FEND] <= frameEndInFifo;
      auxQ[B_LOST] <= lostFrame;
    end
  end

  // end-of-transmission mark: FIFO write clear beats CPU set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              auxQ[B_EOT] <= 1'b0;
    else if (txGrpClr)      auxQ[B_EOT] <= 1'b0;
    else if (txFifoWrite)   auxQ[B_EOT] <= 1'b0;
    else if (strobe.eotSet) auxQ[B_EOT] <= 1'b1;
  end

  // halted on frame end: hardware set beats write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               auxQ[B_HALT] <= 1'b0;
    else if (strobe.clrAll)                  auxQ[B_HALT] <= 1'b0;
    else if (frameLenDone && frameStopMode)  auxQ[B_HALT] <= 1'b1;
    else if (strobe.haltClr)                 auxQ[B_HALT] <= 1'b0;
  end

  // sticky event bits, each cleared by its own soft-reset group
  for (genvar g = 0; g < EV_W; g++) begin : gEvt
    localparam int BIT = B_EV0 + g;
    logic grpClr;
    assign grpClr = strobe.clrAll
                  | (strobe.clrRx & RX_CLR_MASK[BIT])
                  | (strobe.clrTx & TX_CLR_MASK[BIT]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            auxQ[BIT] <= 1'b0;
      else if (grpClr)      auxQ[BIT] <= 1'b0;
      else if (auxEvent[g]) auxQ[BIT] <= 1'b1;
    end
  end
endmodule

// File: rtl/aux_status_reg.sv
module aux_status_reg
  import aux_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              extMode,
  input  logic              modeChange,
  input  logic              txSoftRst,
  input  logic              rxSoftRst,
  input  logic              cpuSel,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              rxTimeout,
  input  logic              rxFifoRead,
  input  logic              frameEndInFifo,
  input  logic              txFifoWrite,
  input  logic              frameLenDone,
  input  logic              frameStopMode,
  input  logic              lostFrame,
  input  logic [EV_W-1:0]   auxEvent,
  output logic              txEotMark,
  output logic              txHalted
);
  auxStrobeT         strobe;
  logic [DATA_W-1:0] auxQ;
  logic [DATA_W-1:0] scrQ;

  aux_status_ctrl u_ctrl (
    .extMode(extMode), .modeChange(modeChange), .txSoftRst(txSoftRst),
    .rxSoftRst(rxSoftRst), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .strobe(strobe)
  );

  aux_status_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWrData(cpuWrData),
    .rxTimeout(rxTimeout), .rxFifoRead(rxFifoRead),
    .frameEndInFifo(frameEndInFifo), .txFifoWrite(txFifoWrite),
    .frameLenDone(frameLenDone), .frameStopMode(frameStopMode),
    .lostFrame(lostFrame), .auxEvent(auxEvent), .auxQ(auxQ), .scrQ(scrQ)
  );

  assign cpuRdData = extMode ? auxQ : scrQ;
  assign txEotMark = txFifoWrite & auxQ[B_EOT];
  assign txHalted  = auxQ[B_HALT];
endmodule

// File: rtl/aux_status_chk.sv
module aux_status_chk
  import aux_status_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              extMode,
  input logic              modeChange,
  input logic              txSoftRst,
  input logic              rxSoftRst,
  input logic              cpuSel,
  input logic              cpuWr,
  input logic [DATA_W-1:0] cpuWrData,
  input logic              rxFifoRead,
  input logic              frameEndInFifo,
  input logic              txFifoWrite,
  input logic              frameLenDone,
  input logic              frameStopMode,
  input logic [DATA_W-1:0] auxQ,
  input logic [DATA_W-1:0] scrQ
);
  AST_MODE_CLEARS_AUX: assert property (@(posedge clk) disable iff (!rstN)
    modeChange |=> auxQ == '0); // R2
  AST_RX_SOFT_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    rxSoftRst |=> (auxQ & RX_CLR_MASK) == '0); // R3
  AST_TX_SOFT_GROUP: assert property (@(posedge clk) disable iff (!rstN)
    txSoftRst |=> (auxQ & TX_CLR_MASK) == '0); // R3
  AST_READ_CLEARS_TOUT: assert property (@(posedge clk) disable iff (!rstN)
    rxFifoRead |=> !auxQ[B_TOUT]); // R4
  AST_FEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (!modeChange && !rxSoftRst) |=> auxQ[B_FEND] == $past(frameEndInFifo)); // R5
  AST_EOT_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    txFifoWrite |=> !auxQ[B_EOT]); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (auxQ[B_HALT] && !modeChange && !(cpuSel && cpuWr && extMode && cpuWrData[B_HALT]))
    |=> auxQ[B_HALT]); // R7
  AST_HALT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (frameLenDone && frameStopMode && !modeChange) |=> auxQ[B_HALT]); // R7
  AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuSel && cpuWr && !extMode) |=> $stable(scrQ)); // R11
endmodule

bind aux_status_reg aux_status_chk u_chk (
  .clk(clk), .rstN(rstN), .extMode(extMode), .modeChange(modeChange),
  .txSoftRst(txSoftRst), .rxSoftRst(rxSoftRst), .cpuSel(cpuSel), .cpuWr(cpuWr),
  .cpuWrData(cpuWrData), .rxFifoRead(rxFifoRead), .frameEndInFifo(frameEndInFifo),
  .txFifoWrite(txFifoWrite), .frameLenDone(frameLenDone),
  .frameStopMode(frameStopMode), .auxQ(auxQ), .scrQ(scrQ)
);

// File: tb/aux_status_reg_tb.sv
`timescale 1ns/1ps
module aux_status_reg_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       extMode, modeChange, txSoftRst, rxSoftRst, cpuSel, cpuWr;
  logic [7:0] cpuWrData, cpuRdData;
  logic       rxTimeout, rxFifoRead, frameEndInFifo, txFifoWrite;
  logic       frameLenDone, frameStopMode, lostFrame;
  logic [2:0] auxEvent;
  logic       txEotMark, txHalted;

  int errors = 0;
  int checks = 0;
  logic [7:0] mAux, mScr;
  logic [31:0] lfsr = 32'hACE1_2461;
  bit finished = 0;

  always #5 clk = ~clk;

  aux_status_reg u_dut (
    .clk(clk), .rstN(rstN), .extMode(extMode), .modeChange(modeChange),
    .txSoftRst(txSoftRst), .rxSoftRst(rxSoftRst), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .rxTimeout(rxTimeout),
    .rxFifoRead(rxFifoRead), .frameEndInFifo(frameEndInFifo),
    .txFifoWrite(txFifoWrite), .frameLenDone(frameLenDone),
    .frameStopMode(frameStopMode), .lostFrame(lostFrame), .auxEvent(auxEvent),
    .txEotMark(txEotMark), .txHalted(txHalted)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // expected next state, derived from the requirement list
  task automatic modelStep();
    logic [7:0] n;
    logic wrA, wrS;
    wrA = cpuSel & cpuWr & extMode;
    wrS = cpuSel & cpuWr & ~extMode;
    n = mAux;
    if (rxFifoRead) n[0] = 1'b0; else if (rxTimeout) n[0] = 1'b1;
    n[1] = frameEndInFifo;
    if (txFifoWrite) n[2] = 1'b0; else if (wrA && cpuWrData[2]) n[2] = 1'b1;
    if (frameLenDone && frameStopMode) n[3] = 1'b1;
    else if (wrA && cpuWrData[3]) n[3] = 1'b0;
    n[4] = lostFrame;
    for (int i = 0; i < 3; i++) if (auxEvent[i]) n[5+i] = 1'b1;
    if (rxSoftRst) n = n & 8'b1100_1100;
    if (txSoftRst) n = n & 8'b1011_1011;
    if (modeChange) n = 8'h00;
    mAux = n;
    if (wrS) mScr = cpuWrData;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    #1;
  endtask

  // read both bytes through the shared address and compare bit by bit
  task automatic checkAll();
    logic saveMode;
    logic [7:0] a, s;
    saveMode = extMode;
    extMode = 1'b1; #1; a = cpuRdData;
    extMode = 1'b0; #1; s = cpuRdData;
    extMode = saveMode; #1;
    check(a[0] == mAux[0], "R4 tout bit", a[0], mAux[0]);
    check(a[1] == mAux[1], "R5 fend bit", a[1], mAux[1]);
    check(a[2] == mAux[2], "R6 eot bit",  a[2], mAux[2]);
    check(a[3] == mAux[3], "R7 halt bit", a[3], mAux[3]);
    check(txHalted == mAux[3], "R7 txHalted", txHalted, mAux[3]);
    check(a[4] == mAux[4], "R8 lost bit", a[4], mAux[4]);
    check(a[7:5] == mAux[7:5], "R9 event bits", a[7:5], mAux[7:5]);
    check(s == mScr, "R11 scratchpad", s, mScr);
  endtask

  task automatic idle();
    modeChange = 0; txSoftRst = 0; rxSoftRst = 0; cpuSel = 0; cpuWr = 0;
    cpuWrData = 0; rxTimeout = 0; rxFifoRead = 0; frameEndInFifo = 0;
    txFifoWrite = 0; frameLenDone = 0; frameStopMode = 0; lostFrame = 0;
    auxEvent = 0;
  endtask

  function automatic logic [31:0] nextLfsr(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    extMode = 0;
    rstN = 0;
    mAux = 0; mScr = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    // R2: reset state of both bytes
    check(cpuRdData == 8'h00, "R2 scratch after reset", cpuRdData, 0);
    extMode = 1; #1;
    check(cpuRdData == 8'h00, "R2 aux after reset", cpuRdData, 0);

    // R11/R1: sweep every scratchpad value in non-extended mode
    extMode = 0;
    for (int v = 0; v < 256; v++) begin
      cpuSel = 1; cpuWr = 1; cpuWrData = 8'(v);
      tick();
      cpuSel = 0; cpuWr = 0; #1;
      check(cpuRdData == 8'(v), "R1 R11 scratch readback", cpuRdData, v);
    end

    // R10/R6: extended write of all ones sets only the end-of-transmission mark
    extMode = 1;
    cpuSel = 1; cpuWr = 1; cpuWrData = 8'hFF;
    tick();
    mScr = 8'hFF;
    cpuSel = 0; cpuWr = 0; #1;
    check(cpuRdData == 8'h04, "R10 R6 aux after 0xFF write", cpuRdData, 8'h04);
    extMode = 0; #1;
    check(cpuRdData == 8'hFF, "R10 scratch untouched by aux write", cpuRdData, 8'hFF);
    extMode = 1;
    // R6: the transmit FIFO write carries the mark, then the bit clears
    txFifoWrite = 1; #1;
    check(txEotMark == 1'b1, "R6 txEotMark with mark set", txEotMark, 1);
    tick();
    txFifoWrite = 0; #1;
    check(cpuRdData[2] == 1'b0, "R6 mark cleared by FIFO write", cpuRdData[2], 0);
    txFifoWrite = 1; #1;
    check(txEotMark == 1'b0, "R6 no mark when bit clear", txEotMark, 0);
    txFifoWrite = 0;
    mAux = 8'h00;
    // R7: set wins over simultaneous write-one-to-clear
    frameLenDone = 1; frameStopMode = 1; cpuSel = 1; cpuWr = 1; cpuWrData = 8'h08;
    tick();
    idle(); #1;
    check(txHalted == 1'b1, "R7 set beats clear", txHalted, 1);
    cpuSel = 1; cpuWr = 1; cpuWrData = 8'h00;
    tick();
    idle(); #1;
    check(txHalted == 1'b1, "R10 write 0 keeps halt", txHalted, 1);
    cpuSel = 1; cpuWr = 1; cpuWrData = 8'h08;
    tick();
    idle(); #1;
    check(txHalted == 1'b0, "R7 write 1 clears halt", txHalted, 0);
    // R4: timeout and read together -> stays clear
    rxTimeout = 1; rxFifoRead = 1;
    tick();
    idle(); #1;
    check(cpuRdData[0] == 1'b0, "R4 read wins", cpuRdData[0], 0);
    mAux = cpuRdData;

    // pseudo-random sweep against the model
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      lfsr = nextLfsr(lfsr); lfsr = nextLfsr(lfsr); lfsr = nextLfsr(lfsr);
      r = lfsr;
      lfsr = nextLfsr(lfsr);
      if (r[3:0] == 4'd0) extMode = ~extMode;
      modeChange    = (r[9:4] == 6'd0);
      txSoftRst     = (r[14:10] == 5'd1);
      rxSoftRst     = (r[19:15] == 5'd2);
      cpuSel        = r[20];
      cpuWr         = r[21] & r[22];
      cpuWrData     = lfsr[31:24];
      rxTimeout     = r[23] & r[24];
      rxFifoRead    = r[25] & r[26] & r[27];
      frameEndInFifo= r[28];
      txFifoWrite   = r[29] & r[30];
      frameLenDone  = lfsr[5] & lfsr[6] & lfsr[7];
      frameStopMode = lfsr[8];
      lostFrame     = lfsr[9];
      auxEvent      = lfsr[12:10] & lfsr[15:13] & lfsr[18:16];
      #1;
      check(txEotMark == (txFifoWrite & mAux[2]), "R6 txEotMark", txEotMark,
            txFifoWrite & mAux[2]);
      check(cpuRdData == (extMode ? mAux : mScr), "R1 read select", cpuRdData,
            extMode ? mAux : mScr);
      tick();
      checkAll();
    end

    idle();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule